// File: doc/BRIEF.md
# Bunch-Train Acquisition Sequencer

This block sequences a pixel sensor through the operating cycle of a pulsed collider beam. Beam arrives in short bursts of bunch crossings separated by long quiet gaps. Each burst has three phases, in this order. First, the pixel front ends are held in reset for a programmable number of clocks. Second, bunch crossings are counted while acquisition is enabled. Third, a readout window opens in the gap so the stored hits can be drained. The block then returns to idle and waits for the next train trigger.

During acquisition a clock divider produces one crossing strobe every `CLK_DIV` clocks. At 125 MHz the default spacing is about 150 ns, which is close to the 6.7 MHz crossing rate. The timestamp that goes to the hit logic is the index of the current crossing, 13 bits wide. A train has 14000 crossings by default, about 2 ms, and trains repeat every 100 ms. The crossing count and the reset length are sampled when the trigger is accepted. Trains longer than the timestamp range saturate the timestamp rather than letting it wrap, and they raise a sticky flag. Triggers that arrive while a train is in progress are dropped and recorded in a second sticky flag.

Top module: `train_sequencer`

## Requirements
- R1: While `rst_n` is low, and on release from it, `pix_reset`, `acq_en`, `ro_en`, `xing_strobe`, `ts_overflow` and `missed_trig` are 0 and `timestamp` is 0. An assertion of `rst_n` in the middle of a train returns the block to idle.
- R2: A `train_start` sampled high in idle makes `pix_reset` go high from the next cycle. It stays high for L cycles, where L is `reset_len` as sampled with the trigger and a value of 0 counts as 1.
- R3: `acq_en` rises in the cycle right after the last `pix_reset` cycle. During acquisition `xing_strobe` pulses for one cycle at every CLK_DIV-th cycle, and the first pulse falls in acquisition cycle CLK_DIV. Exactly N pulses occur, and acquisition lasts N*CLK_DIV cycles. N is `crossings_cfg` as sampled with the trigger, and 0 counts as 1.
- R4: `timestamp` is 0 when acquisition begins. In the cycle of each crossing strobe it equals the 0-based index of that crossing, and it advances by one after each strobe.
- R5: `timestamp` saturates at 8191 and never wraps. `ts_overflow` goes high in the cycle after the strobe of crossing index 8192 or above, and it stays high until `rst_n`. A train of 8192 crossings leaves it low.
- R6: `ro_en` rises in the cycle after the final crossing strobe and stays high until `readout_done` is sampled high. The block is idle in the following cycle.
- R7: At most one of `pix_reset`, `acq_en` and `ro_en` is high in any cycle, and `xing_strobe` is high only while `acq_en` is high.
- R8: A `train_start` sampled outside idle has no effect on the running train. It sets `missed_trig`, which stays high until `rst_n`.
- R9: A `readout_done` sampled outside the readout phase has no effect.
- R10: Changes to `reset_len` or `crossings_cfg` after the trigger has been accepted do not alter the running train.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| train_start | input | 1 | Trigger that starts a train, accepted only in idle |
| reset_len | input | 8 | Number of pixel-reset cycles (0 counts as 1) |
| crossings_cfg | input | 16 | Crossings per train (0 counts as 1) |
| readout_done | input | 1 | Ends the readout window |
| pix_reset | output | 1 | Pixel front-end reset phase |
| acq_en | output | 1 | Acquisition phase |
| xing_strobe | output | 1 | One-cycle pulse per bunch crossing |
| timestamp | output | 13 | Current crossing index, saturating |
| ro_en | output | 1 | Readout window between trains |
| ts_overflow | output | 1 | Sticky: timestamp has saturated |
| missed_trig | output | 1 | Sticky: a trigger was dropped |

## Verification
A wrong phase state shows within one cycle as overlapping phase enables, or as a phase that is too short or too long. A wrong reload of the divider or the crossing counter shows at the first strobe as a gap other than CLK_DIV, or as a timestamp that does not start at 0. An off-by-one in the train length shows only at the end of acquisition, as one strobe too many or too few. Saturation errors show only at crossing index 8192. For that reason the bench runs trains of 8192 and of 8193 crossings to reach both sides of that boundary.

// File: rtl/train_sequencer.sv
module train_sequencer #(
  parameter int CLK_DIV = 19,
  parameter int TS_W    = 13,
  parameter int CNT_W   = 16,
  parameter int RL_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             train_start,
  input  logic [RL_W-1:0]  reset_len,
  input  logic [CNT_W-1:0] crossings_cfg,
  input  logic             readout_done,
  output logic             pix_reset,
  output logic             acq_en,
  output logic             xing_strobe,
  output logic [TS_W-1:0]  timestamp,
  output logic             ro_en,
  output logic             ts_overflow,
  output logic             missed_trig
);

  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);
  localparam logic [TS_W-1:0] TS_MAX = '1;

  typedef enum logic [1:0] {PH_IDLE, PH_RST, PH_ACQ, PH_RDO} phase_t;

  phase_t           phase;
  logic [RL_W-1:0]  rst_left;
  logic [CNT_W-1:0] xing_goal;
  logic [CNT_W-1:0] xing_cnt;
  logic [DIV_W-1:0] div_cnt;

  logic div_last, last_xing, ts_sat;

  assign pix_reset   = (phase == PH_RST);
  assign acq_en      = (phase == PH_ACQ);
  assign ro_en       = (phase == PH_RDO);
  assign div_last    = (div_cnt == DIV_LAST);
  assign xing_strobe = acq_en && div_last;
  assign last_xing   = xing_strobe && (xing_cnt == xing_goal - 1'b1);
  assign ts_sat      = (xing_cnt > CNT_W'(TS_MAX));
  assign timestamp   = ts_sat ? TS_MAX : xing_cnt[TS_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      rst_left  <= '0;
      xing_goal <= '0;
      xing_cnt  <= '0;
      div_cnt   <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (train_start) begin
          phase     <= PH_RST;
          rst_left  <= (reset_len == '0) ? RL_W'(1) : reset_len;
          xing_goal <= (crossings_cfg == '0) ? CNT_W'(1) : crossings_cfg;
          xing_cnt  <= '0;
        end
        PH_RST: begin
          if (rst_left == RL_W'(1)) begin
            phase   <= PH_ACQ;
            div_cnt <= '0;
          end else begin
            rst_left <= rst_left - 1'b1;
          end
        end
        PH_ACQ: begin
          div_cnt <= div_last ? '0 : div_cnt + 1'b1;
          if (xing_strobe) xing_cnt <= xing_cnt + 1'b1;
          if (last_xing) phase <= PH_RDO;
        end
        PH_RDO: if (readout_done) phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts_overflow <= 1'b0;
      missed_trig <= 1'b0;
    end else begin
      if (xing_strobe && ts_sat) ts_overflow <= 1'b1;
      if (train_start && phase != PH_IDLE) missed_trig <= 1'b1;
    end
  end

  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pix_reset, acq_en, ro_en})); // R7
  AST_STROBE_IN_ACQ: assert property (@(posedge clk) disable iff (!rst_n)
    xing_strobe |-> acq_en); // R7
  AST_ACQ_AFTER_RST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acq_en) |-> $past(pix_reset)); // R3
  AST_TS_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acq_en) |-> timestamp == '0); // R4
  AST_TS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (xing_strobe && timestamp != TS_MAX) |=> timestamp == $past(timestamp) + 1'b1); // R4
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ts_overflow |=> ts_overflow); // R5
  AST_MISSED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    missed_trig |=> missed_trig); // R8
  AST_RO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ro_en && !readout_done) |=> ro_en); // R6
  AST_RO_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (ro_en && readout_done) |=> !ro_en && !pix_reset && !acq_en); // R6

endmodule

// File: tb/train_sequencer_test.sv
module train_sequencer_test;

  localparam int D = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        train_start = 1'b0;
  logic [7:0]  reset_len = 8'd0;
  logic [15:0] crossings_cfg = 16'd0;
  logic        readout_done = 1'b0;
  logic        pix_reset, acq_en, xing_strobe, ro_en, ts_overflow, missed_trig;
  logic [12:0] timestamp;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  train_sequencer #(.CLK_DIV(D)) uut (
    .clk(clk), .rst_n(rst_n), .train_start(train_start), .reset_len(reset_len),
    .crossings_cfg(crossings_cfg), .readout_done(readout_done),
    .pix_reset(pix_reset), .acq_en(acq_en), .xing_strobe(xing_strobe),
    .timestamp(timestamp), .ro_en(ro_en), .ts_overflow(ts_overflow),
    .missed_trig(missed_trig)
  );

  localparam int NV = 6;
  localparam logic [23:0] VEC [NV] = '{
    {8'd4, 16'd5}, {8'd1, 16'd1}, {8'd0, 16'd3},
    {8'd10, 16'd0}, {8'd255, 16'd2}, {8'd2, 16'd40}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_train(input int l, input int n, input bit mid_change, input bit poke);
    int el, en, rc, ac, sc, last, sp_bad, ts_bad, ex_bad, exp_ts;
    el = (l == 0) ? 1 : l;
    en = (n == 0) ? 1 : n;
    reset_len = 8'(l);
    crossings_cfg = 16'(n);
    @(negedge clk) train_start = 1'b1;
    @(negedge clk) train_start = 1'b0;
    if (mid_change) begin
      reset_len = 8'd7;
      crossings_cfg = 16'd99;
    end
    rc = 0; ex_bad = 0;
    while (pix_reset && rc < 1000) begin
      if (!$onehot0({pix_reset, acq_en, ro_en}) || xing_strobe) ex_bad++;
      rc++;
      @(negedge clk);
    end
    chk(rc == el, "R2 reset length", rc, el);
    chk(acq_en == 1'b1, "R3 acquire follows reset", int'(acq_en), 1);
    chk(timestamp == 13'd0, "R4 timestamp at acquire start", int'(timestamp), 0);
    ac = 0; sc = 0; last = 0; sp_bad = 0; ts_bad = 0;
    while (acq_en && ac < 100000) begin
      if (!$onehot0({pix_reset, acq_en, ro_en})) ex_bad++;
      ac++;
      if (xing_strobe) begin
        if (ac - last != D) sp_bad++;
        exp_ts = (sc > 8191) ? 8191 : sc;
        if (int'(timestamp) != exp_ts) ts_bad++;
        last = ac;
        sc++;
      end
      if (poke && ac == 2) begin
        train_start = 1'b1;
        readout_done = 1'b1;
      end
      if (poke && ac == 3) begin
        train_start = 1'b0;
        readout_done = 1'b0;
      end
      @(negedge clk);
    end
    chk(ac == en * D, "R3 acquire length", ac, en * D);
    chk(sc == en, "R3 strobe count", sc, en);
    chk(sp_bad == 0, "R3 strobe spacing errors", sp_bad, 0);
    chk(ts_bad == 0, "R4 timestamp errors", ts_bad, 0);
    chk(ex_bad == 0, "R7 phase exclusivity errors", ex_bad, 0);
    chk(ro_en == 1'b1, "R6 readout opens", int'(ro_en), 1);
    repeat (3) @(negedge clk);
    chk(ro_en == 1'b1 && !xing_strobe, "R6 readout held", int'(ro_en), 1);
    readout_done = 1'b1;
    @(negedge clk) readout_done = 1'b0;
    chk({pix_reset, acq_en, ro_en} == 3'b000, "R6 idle after readout",
        int'({pix_reset, acq_en, ro_en}), 0);
  endtask

  initial begin
    #(8 * 190000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({pix_reset, acq_en, ro_en, xing_strobe, ts_overflow, missed_trig} == 6'b0
        && timestamp == 13'd0, "R1 reset state",
        int'({pix_reset, acq_en, ro_en, xing_strobe, ts_overflow, missed_trig}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!pix_reset && !acq_en && !ro_en, "R1 idle after release",
        int'({pix_reset, acq_en, ro_en}), 0);

    for (int i = 0; i < NV; i++)
      run_train(int'(VEC[i][23:16]), int'(VEC[i][15:0]), 1'b0, 1'b0);
    chk(missed_trig == 1'b0, "R8 no missed trigger yet", int'(missed_trig), 0);

    run_train(2, 5, 1'b1, 1'b0);   // R10
    run_train(3, 4, 1'b0, 1'b1);   // R8 R9
    chk(missed_trig == 1'b1, "R8 missed trigger flagged", int'(missed_trig), 1);

    // R5: boundary on each side of saturation
    run_train(1, 8192, 1'b0, 1'b0);
    chk(ts_overflow == 1'b0, "R5 no overflow at 8192", int'(ts_overflow), 0);
    chk(timestamp == 13'd8191, "R5 saturated value", int'(timestamp), 8191);
    run_train(1, 8193, 1'b0, 1'b0);
    chk(ts_overflow == 1'b1, "R5 overflow at 8193", int'(ts_overflow), 1);
    chk(timestamp == 13'd8191, "R5 no wrap", int'(timestamp), 8191);

    // R1: reset in the middle of a train
    reset_len = 8'd1;
    crossings_cfg = 16'd50;
    @(negedge clk) train_start = 1'b1;
    @(negedge clk) train_start = 1'b0;
    repeat (10) @(negedge clk);
    chk(acq_en == 1'b1, "R1 mid-train setup", int'(acq_en), 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk({pix_reset, acq_en, ro_en, ts_overflow, missed_trig} == 5'b0 && timestamp == 13'd0,
        "R1 reset mid-train", int'({pix_reset, acq_en, ro_en, ts_overflow, missed_trig}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_train(2, 3, 1'b0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule